// File: doc/BRIEF.md
# Flash Common Flash Interface Query Probe Engine

This block is a small bus master that identifies a parallel NOR flash array built from two 16-bit devices placed side by side on a 32-bit data bus. A one-cycle start pulse launches a fixed sequence. The engine writes the query command and confirms that both devices return the three-character query signature. It then reads the system-interface and geometry fields and the erase-region descriptors. It finishes by putting the array back into read-array mode.

The engine keeps only the lower device's byte lane. It turns the compressed encodings into values that firmware or other logic can use directly: supply voltages in millivolts, timeouts as plain unit counts, device and write-buffer sizes in bytes, and, for each erase region, a block count and a block size. When the signature does not match, the engine reports that no device is present and stops. It issues no further bus cycles in that case.

Top module: `cfi_probe_engine`

## Requirements
- R1: Every bus address is a word offset shifted left by two, so bits 1:0 are always zero. A command byte is placed in both halves of the write data as {8'h00,cmd,8'h00,cmd}. The first transaction of every probe is a write of 32'h0098_0098 to address 32'h154 (word 0x55).
- R2: The engine then reads words 0x10, 0x11 and 0x12 (addresses 0x40, 0x44, 0x48). These must return exactly 32'h0051_0051, 32'h0052_0052 and 32'h0059_0059. At the first mismatch the engine pulses done with no_device=1 and issues no further bus transaction, not even the read-array write.
- R3: After a good signature the engine reads words 0x1B to 0x2C once each, in ascending order. It then reads the region descriptor words, and then writes 32'h00FF_00FF to address 0. After that write is acknowledged, done goes high for exactly one cycle with no_device=0.
- R4: volt_mv holds four 16-bit fields, from low to high: minimum core supply (word 0x1B), maximum core supply (0x1C), minimum program supply (0x1D) and maximum program supply (0x1E). A byte b decodes to b[7:4]*1000 + b[3:0]*100.
- R5: typ_tmo holds four TMO_W-bit fields, from low to high: single write (0x1F), buffer write (0x20), block erase (0x21) and chip erase (0x22). A byte n decodes to 2^n, and n=0 decodes to 0.
- R6: max_tmo uses the same field order, from words 0x23 to 0x26. A maximum byte m decodes to 2^(n+m), where n is the matching typical byte. The result is 0 when n or m is 0. Any power of two with exponent at or above TMO_W reads as all ones. The same rule applies to the sizes in R7.
- R7: dev_size is 2^n, where n is the byte at word 0x27. wbuf_size is 2^e, where e is the 16-bit field read low byte first from words 0x2A and 0x2B. Only bits 7:0 of every parameter read are used.
- R8: Region i's descriptor sits at words 0x2D+4i to 0x30+4i. Its block count is the first 16-bit field plus one. Its block size is the second 16-bit field times 256, or 128 when that field is zero. Region i occupies region_blocks[17i+16:17i] and region_bytes[24i+23:24i]. Regions at or above region_count read as zero.
- R9: region_count is the byte at word 0x2C. If that byte exceeds MAX_REG, region_count is clamped to MAX_REG, region_clamped is set, and only MAX_REG descriptors are read. A count of zero skips all descriptor reads.
- R10: Once a request is raised, bus_req, bus_addr, bus_we and bus_wdata stay unchanged until bus_ack is seen.
- R11: busy rises in the cycle after start. A start pulse while busy neither restarts nor lengthens the probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a probe (ignored while busy) |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| no_device | output | 1 | Signature mismatch seen in the last probe |
| region_clamped | output | 1 | Reported region count exceeded MAX_REG |
| region_count | output | CNT_W | Number of stored regions |
| volt_mv | output | 64 | Four supply voltages in millivolts |
| typ_tmo | output | 4*TMO_W | Four typical timeouts |
| max_tmo | output | 4*TMO_W | Four maximum timeouts |
| dev_size | output | TMO_W | Device size in bytes |
| wbuf_size | output | TMO_W | Write-buffer size in bytes |
| region_blocks | output | 17*MAX_REG | Per-region block counts |
| region_bytes | output | 24*MAX_REG | Per-region block sizes in bytes |

## Verification
The slave model raises bus_ack one cycle after each request, and the engine moves to the next transaction on the following edge. A probe with k descriptor reads therefore takes two cycles for each of its 23+k transactions, and done arrives on the edge after the final acknowledge. The bench logs every acknowledged transaction at the clock edge. After each probe it compares that log, entry by entry, against the sequence it expects. It then waits for done, steps one falling edge past the pulse, and compares the decoded outputs, because they are registered from bytes captured on earlier acknowledges. It counts done pulses across a few further idle cycles to confirm that done lasts one cycle and that a start pulse during a probe adds none.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_SIG,
        ST_PARM,
        ST_REG,
        ST_EXIT,
        ST_FIN
    } probe_st_e;

    localparam logic [7:0] WO_QUERY  = 8'h55;
    localparam logic [7:0] WO_SIG    = 8'h10;
    localparam logic [7:0] WO_PARM   = 8'h1B;
    localparam logic [7:0] WO_REGION = 8'h2D;
    localparam logic [7:0] CMD_QUERY = 8'h98;
    localparam logic [7:0] CMD_ARRAY = 8'hFF;
    localparam int N_PARM   = 18;
    localparam int IX_COUNT = 17;
    localparam int N_KEEP   = 15;

    function automatic logic [31:0] mirror_byte(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    function automatic logic [31:0] sig_word(input logic [1:0] k);
        case (k)
            2'd0:    return mirror_byte(8'h51);
            2'd1:    return mirror_byte(8'h52);
            default: return mirror_byte(8'h59);
        endcase
    endfunction

endpackage

// File: rtl/cfi_param_decode.sv
module cfi_param_decode #(
    parameter int TMO_W = 32
) (
    input  logic [8*15-1:0]    raw,
    output logic [63:0]        volt_mv,
    output logic [4*TMO_W-1:0] typ_tmo,
    output logic [4*TMO_W-1:0] max_tmo,
    output logic [TMO_W-1:0]   dev_size,
    output logic [TMO_W-1:0]   wbuf_size
);

    function automatic logic [TMO_W-1:0] pow2_sat(input logic [16:0] e);
        if (e >= 17'(TMO_W))
            return '1;
        return TMO_W'(1) << e;
    endfunction

    for (genvar i = 0; i < 4; i++) begin : g_field
        logic [7:0] v_b, t_b, m_b;
        assign v_b = raw[8*i +: 8];
        assign t_b = raw[8*(4+i) +: 8];
        assign m_b = raw[8*(8+i) +: 8];
        assign volt_mv[16*i +: 16] = 16'(v_b[7:4]) * 16'd1000 + 16'(v_b[3:0]) * 16'd100;
        assign typ_tmo[TMO_W*i +: TMO_W] = (t_b == 8'd0) ? '0 : pow2_sat(17'(t_b));
        assign max_tmo[TMO_W*i +: TMO_W] = (t_b == 8'd0 || m_b == 8'd0) ? '0
                                         : pow2_sat(17'(t_b) + 17'(m_b));
    end

    assign dev_size  = pow2_sat(17'(raw[8*12 +: 8]));
    assign wbuf_size = pow2_sat(17'({raw[8*14 +: 8], raw[8*13 +: 8]}));

endmodule

// File: rtl/cfi_region_decode.sv
module cfi_region_decode (
    input  logic [31:0] desc,
    input  logic        valid,
    output logic [16:0] blocks,
    output logic [23:0] block_bytes
);

    logic [15:0] cnt_f, size_f;

    assign cnt_f  = desc[15:0];
    assign size_f = desc[31:16];

    always_comb begin
        if (!valid) begin
            blocks      = '0;
            block_bytes = '0;
        end else begin
            blocks      = {1'b0, cnt_f} + 17'd1;
            block_bytes = (size_f == 16'd0) ? 24'd128 : {size_f, 8'h00};
        end
    end

endmodule

// File: rtl/cfi_probe_engine.sv
module cfi_probe_engine
    import cfi_probe_pkg::*;
#(
    parameter int MAX_REG = 4,
    parameter int TMO_W   = 32,
    localparam int CNT_W  = $clog2(MAX_REG + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [31:0]           bus_addr,
    output logic [31:0]           bus_wdata,
    input  logic                  bus_ack,
    input  logic [31:0]           bus_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  no_device,
    output logic                  region_clamped,
    output logic [CNT_W-1:0]      region_count,
    output logic [63:0]           volt_mv,
    output logic [4*TMO_W-1:0]    typ_tmo,
    output logic [4*TMO_W-1:0]    max_tmo,
    output logic [TMO_W-1:0]      dev_size,
    output logic [TMO_W-1:0]      wbuf_size,
    output logic [17*MAX_REG-1:0] region_blocks,
    output logic [24*MAX_REG-1:0] region_bytes
);

    localparam int IDX_MAX = (4 * MAX_REG > N_PARM) ? 4 * MAX_REG : N_PARM;
    localparam int IDX_W   = $clog2(IDX_MAX) + 1;

    typedef struct packed {
        probe_st_e              st;
        logic [IDX_W-1:0]       idx;
        logic [8*N_KEEP-1:0]    raw;
        logic [32*MAX_REG-1:0]  rg;
        logic [CNT_W-1:0]       cnt;
        logic                   nodev;
        logic                   clamp;
    } probe_s;

    probe_s q, n;

    logic [7:0]       word;
    logic [7:0]       rbyte;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] reg_last;
    logic             keep;

    assign rbyte    = bus_rdata[7:0];
    assign keep     = (q.idx != IDX_W'(13)) && (q.idx != IDX_W'(14)) && (q.idx != IDX_W'(IX_COUNT));
    assign pos      = (q.idx < IDX_W'(13)) ? q.idx : q.idx - IDX_W'(2);
    assign reg_last = IDX_W'({q.cnt, 2'b00}) - IDX_W'(1);

    always_comb begin
        n = q;
        case (q.st)
            ST_IDLE: if (start) begin
                n.st    = ST_CMD;
                n.idx   = '0;
                n.raw   = '0;
                n.rg    = '0;
                n.cnt   = '0;
                n.nodev = 1'b0;
                n.clamp = 1'b0;
            end
            ST_CMD: if (bus_ack) n.st = ST_SIG;
            ST_SIG: if (bus_ack) begin
                if (bus_rdata != sig_word(q.idx[1:0])) begin
                    n.nodev = 1'b1;
                    n.st    = ST_FIN;
                end else if (q.idx == IDX_W'(2)) begin
                    n.st  = ST_PARM;
                    n.idx = '0;
                end else begin
                    n.idx = q.idx + IDX_W'(1);
                end
            end
            ST_PARM: if (bus_ack) begin
                if (keep) n.raw[8*pos +: 8] = rbyte;
                if (q.idx == IDX_W'(IX_COUNT)) begin
                    n.idx = '0;
                    if (rbyte > 8'(MAX_REG)) begin
                        n.cnt   = CNT_W'(MAX_REG);
                        n.clamp = 1'b1;
                    end else begin
                        n.cnt = CNT_W'(rbyte);
                    end
                    n.st = (rbyte == 8'd0) ? ST_EXIT : ST_REG;
                end else begin
                    n.idx = q.idx + IDX_W'(1);
                end
            end
            ST_REG: if (bus_ack) begin
                n.rg[8*q.idx +: 8] = rbyte;
                if (q.idx == reg_last) n.st = ST_EXIT;
                else                   n.idx = q.idx + IDX_W'(1);
            end
            ST_EXIT: if (bus_ack) n.st = ST_FIN;
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    always_comb begin
        case (q.st)
            ST_CMD:  word = WO_QUERY;
            ST_SIG:  word = WO_SIG + 8'(q.idx);
            ST_PARM: word = WO_PARM + 8'(q.idx);
            ST_REG:  word = WO_REGION + 8'(q.idx);
            default: word = 8'h00;
        endcase
    end

    assign bus_req   = (q.st == ST_CMD) || (q.st == ST_SIG) || (q.st == ST_PARM)
                    || (q.st == ST_REG) || (q.st == ST_EXIT);
    assign bus_we    = (q.st == ST_CMD) || (q.st == ST_EXIT);
    assign bus_addr  = {22'd0, word, 2'b00};
    assign bus_wdata = (q.st == ST_CMD)  ? mirror_byte(CMD_QUERY)
                     : (q.st == ST_EXIT) ? mirror_byte(CMD_ARRAY) : 32'd0;

    assign busy           = (q.st != ST_IDLE);
    assign done           = (q.st == ST_FIN);
    assign no_device      = q.nodev;
    assign region_clamped = q.clamp;
    assign region_count   = q.cnt;

    cfi_param_decode #(.TMO_W(TMO_W)) u_param (
        .raw       (q.raw),
        .volt_mv   (volt_mv),
        .typ_tmo   (typ_tmo),
        .max_tmo   (max_tmo),
        .dev_size  (dev_size),
        .wbuf_size (wbuf_size)
    );

    for (genvar i = 0; i < MAX_REG; i++) begin : g_region
        cfi_region_decode u_region (
            .desc        (q.rg[32*i +: 32]),
            .valid       (CNT_W'(i) < q.cnt),
            .blocks      (region_blocks[17*i +: 17]),
            .block_bytes (region_bytes[24*i +: 24])
        );
    end

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[1:0] == 2'b00); // R1
    AST_CMD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_wdata[31:16] == bus_wdata[15:0]); // R1
    AST_NODEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_device) |-> done && !bus_req); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        region_clamped |-> region_count == CNT_W'(MAX_REG)); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)); // R10
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy); // R11

endmodule

// File: tb/cfi_probe_engine_tb.sv
`timescale 1ns/1ps
module cfi_probe_engine_tb;

    localparam int MAX_REG = 4;
    localparam int TMO_W   = 32;
    localparam int CNT_W   = $clog2(MAX_REG + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic busy, done, no_device, region_clamped;
    logic [CNT_W-1:0] region_count;
    logic [63:0] volt_mv;
    logic [4*TMO_W-1:0] typ_tmo, max_tmo;
    logic [TMO_W-1:0] dev_size, wbuf_size;
    logic [17*MAX_REG-1:0] region_blocks;
    logic [24*MAX_REG-1:0] region_bytes;

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [0:127];
    logic [31:0] log_addr [0:255];
    logic [31:0] log_data [0:255];
    logic        log_we   [0:255];
    int log_n = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    cfi_probe_engine #(.MAX_REG(MAX_REG), .TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .no_device(no_device), .region_clamped(region_clamped),
        .region_count(region_count), .volt_mv(volt_mv), .typ_tmo(typ_tmo), .max_tmo(max_tmo),
        .dev_size(dev_size), .wbuf_size(wbuf_size),
        .region_blocks(region_blocks), .region_bytes(region_bytes)
    );

    assign bus_rdata = mem[bus_addr[8:2]];

    always @(posedge clk) begin
        if (!rst_n) bus_ack <= 1'b0;
        else        bus_ack <= bus_req && !bus_ack;
        if (rst_n && bus_req && bus_ack && log_n < 256) begin
            log_addr[log_n] <= bus_addr;
            log_data[log_n] <= bus_wdata;
            log_we[log_n]   <= bus_we;
            log_n <= log_n + 1;
        end
        if (rst_n && done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Parameter image: junk in bits 31:8 must be ignored (R7)
    task automatic base_image(input logic [7:0] cnt);
        for (int w = 0; w < 128; w++) mem[w] = 32'h0;
        mem[8'h10] = 32'h0051_0051;
        mem[8'h11] = 32'h0052_0052;
        mem[8'h12] = 32'h0059_0059;
        for (int w = 8'h1B; w <= 8'h2B; w++) mem[w] = 32'hA5A5_A500;
        mem[8'h2C] = {24'hC3C3C3, cnt};
    endtask

    task automatic set_b(input int w, input logic [7:0] b);
        mem[w] = {mem[w][31:8], b};
    endtask

    task automatic set_region(input int i, input logic [15:0] c, input logic [15:0] s);
        mem[8'h2D + 4*i]     = {24'h77_7777, c[7:0]};
        mem[8'h2D + 4*i + 1] = {24'h77_7777, c[15:8]};
        mem[8'h2D + 4*i + 2] = {24'h77_7777, s[7:0]};
        mem[8'h2D + 4*i + 3] = {24'h77_7777, s[15:8]};
    endtask

    int run_base, run_done;

    task automatic run_probe(input bit poke_busy);
        run_base = log_n;
        run_done = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R11 busy after start", busy, 1);
        if (poke_busy) begin
            repeat (9) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
        chk("R3 done seen", done, 1);
        @(negedge clk);
        chk("R3 done one cycle", done, 0);
        repeat (5) @(negedge clk);
        chk("R3 R11 single done pulse", done_cnt - run_done, 1);
    endtask

    // Checks the acknowledged transaction log against the expected order
    task automatic check_seq(input int n_sig, input bit good, input int n_reg);
        int e, bad;
        logic [31:0] ea;
        e = run_base;
        bad = 0;
        if (log_addr[e] !== 32'h154 || log_we[e] !== 1'b1 || log_data[e] !== 32'h0098_0098) bad++;
        e++;
        for (int k = 0; k < n_sig; k++) begin
            ea = 32'h40 + 4*k;
            if (log_addr[e] !== ea || log_we[e] !== 1'b0) bad++;
            e++;
        end
        if (good) begin
            for (int k = 0; k < 18; k++) begin
                ea = (32'h1B + k) << 2;
                if (log_addr[e] !== ea || log_we[e] !== 1'b0) bad++;
                e++;
            end
            for (int k = 0; k < n_reg; k++) begin
                ea = (32'h2D + k) << 2;
                if (log_addr[e] !== ea || log_we[e] !== 1'b0) bad++;
                e++;
            end
            if (log_addr[e] !== 32'h0 || log_we[e] !== 1'b1 || log_data[e] !== 32'h00FF_00FF) bad++;
            e++;
        end
        chk("R1 R2 R3 transaction count", log_n - run_base, e - run_base);
        chk("R1 R3 transaction order", bad, 0);
    endtask

    task automatic t_reset;
        chk("reset busy", busy, 0);
        chk("reset done", done, 0);
        chk("reset bus_req", bus_req, 0);
        chk("reset no_device", no_device, 0);
        chk("reset region_count", region_count, 0);
    endtask

    task automatic t_nominal(input bit poke);
        base_image(8'd2);
        set_b(8'h1B, 8'h27); set_b(8'h1C, 8'h36); set_b(8'h1D, 8'h00); set_b(8'h1E, 8'h85);
        set_b(8'h1F, 8'd4);  set_b(8'h20, 8'd0);  set_b(8'h21, 8'd10); set_b(8'h22, 8'd0);
        set_b(8'h23, 8'd4);  set_b(8'h24, 8'd3);  set_b(8'h25, 8'd4);  set_b(8'h26, 8'd0);
        set_b(8'h27, 8'h16); set_b(8'h2A, 8'd5);  set_b(8'h2B, 8'd0);
        set_region(0, 16'h003F, 16'h0100);
        set_region(1, 16'h0007, 16'h0000);
        run_probe(poke);
        check_seq(3, 1, 8);
        chk("R3 no_device low", no_device, 0);
        chk("R4 voltages", volt_mv, {16'd8500, 16'd0, 16'd3600, 16'd2700});
        chk("R5 typ timeouts lo", typ_tmo[63:0], {32'd0, 32'd16});
        chk("R5 typ timeouts hi", typ_tmo[127:64], {32'd0, 32'd1024});
        chk("R6 max timeouts lo", max_tmo[63:0], {32'd0, 32'd256});
        chk("R6 max timeouts hi", max_tmo[127:64], {32'd0, 32'd16384});
        chk("R7 device size", dev_size, 32'd4194304);
        chk("R7 write buffer", wbuf_size, 32'd32);
        chk("R9 count", region_count, 2);
        chk("R9 not clamped", region_clamped, 0);
        chk("R8 region blocks", region_blocks, {17'd0, 17'd0, 17'd8, 17'd64});
        chk("R8 region bytes", region_bytes, {24'd0, 24'd0, 24'd128, 24'd65536});
    endtask

    task automatic t_bad_sig(input int word, input logic [31:0] v, input int n_sig);
        base_image(8'd1);
        mem[word] = v;
        run_probe(0);
        chk("R2 no_device set", no_device, 1);
        check_seq(n_sig, 0, 0);
        chk("R2 no bus after error", bus_req, 0);
    endtask

    task automatic t_clamp;
        base_image(8'd6);
        set_b(8'h2A, 8'd3); set_b(8'h2B, 8'd1);
        set_region(0, 16'h003F, 16'h0100);
        set_region(1, 16'h0001, 16'h0020);
        set_region(2, 16'hFFFF, 16'hFFFF);
        set_region(3, 16'h0000, 16'h0000);
        run_probe(0);
        check_seq(3, 1, 16);
        chk("R9 clamped flag", region_clamped, 1);
        chk("R9 clamped count", region_count, 4);
        chk("R7 wide exponent saturates", wbuf_size, 32'hFFFF_FFFF);
        chk("R8 clamp blocks", region_blocks, {17'd1, 17'd65536, 17'd2, 17'd64});
        chk("R8 clamp bytes", region_bytes, {24'd128, 24'hFFFF00, 24'd8192, 24'd65536});
    endtask

    task automatic t_saturate;
        base_image(8'd0);
        set_b(8'h1B, 8'hFF);
        set_b(8'h1F, 8'd31); set_b(8'h20, 8'd40); set_b(8'h21, 8'd1); set_b(8'h22, 8'd0);
        set_b(8'h23, 8'd5);  set_b(8'h24, 8'd1);  set_b(8'h25, 8'd0); set_b(8'h26, 8'd7);
        set_b(8'h27, 8'h20); set_b(8'h2A, 8'd31); set_b(8'h2B, 8'd0);
        run_probe(0);
        check_seq(3, 1, 0);
        chk("R4 top voltage", volt_mv[15:0], 16'd16500);
        chk("R5 typ saturate", typ_tmo, {32'd0, 32'd2, 32'hFFFF_FFFF, 32'h8000_0000});
        chk("R6 max saturate", max_tmo, {32'd0, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
        chk("R7 size saturate", dev_size, 32'hFFFF_FFFF);
        chk("R7 write buffer 2^31", wbuf_size, 32'h8000_0000);
        chk("R9 zero regions", region_count, 0);
        chk("R8 regions cleared", region_blocks, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_nominal(0);
        t_bad_sig(8'h11, 32'h0052_0053, 2);
        t_bad_sig(8'h10, 32'h0051_0041, 1);
        t_bad_sig(8'h12, 32'h0159_0059, 3);
        t_nominal(1);
        t_clamp;
        t_saturate;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule